// File: doc/BRIEF.md
# I/O Write Snooper with Scanline-Paced CPU Halt

This block sits beside a CPU and a hardware video/sound controller and drives one halt line that pauses the CPU. The goal is to let legacy software observe I/O state as if it were still generating video itself. The controller sees every CPU address and write strobe, and it receives the scanline timing from the video controller.

The block has three modes. In the off mode it never halts. In the compatibility mode it holds the CPU halted for every active display line. In the selective mode it halts only after the CPU has written into one of several configured address windows, such as the framebuffer, the line indirection table or the sound registers. That halt then lasts for a programmed number of active scanlines, set per window.

All halt transitions happen on scanline boundaries, so the CPU is never released or stopped part way through a line. A small configuration port loads the window bases, masks, line counts and the mode.

Top module: `iowr_halt_ctrl`

## Requirements
- R1: After synchronous reset, `halt` is 0 and the mode is off.
- R2: `halt` changes only on the clock edge at which `line_start` is 1, which is the first edge of each scanline; at all other edges it holds its value.
- R3: In off mode, each line start drives `halt` to 0. CPU writes are ignored while off. Mode code 3 behaves as off.
- R4: In compatibility mode (mode code 1), each line start copies `line_vis` into `halt`.
- R5: A CPU cycle hits window i when `cpu_we` is 1 and (`cpu_addr` AND mask[i]) equals base[i]. The configuration address is {bank[1:0], index[1:0]}. Bank 0 writes base[index], bank 1 writes mask[index] and bank 2 writes the line count of window index, taken from the low 4 data bits. Bank 3 writes the mode from data bits [1:0]. All of these reset to 0.
- R6: In selective mode (mode code 2), a hit on a window with line count N halts the next N active lines and then releases. A count of 0 causes no halt.
- R7: At a line start with `line_vis` 0, `halt` goes to 0 and the pending line count is left unchanged.
- R8: When one write hits several windows, the largest of their line counts applies.
- R9: A hit while lines are still pending sets the pending count to the larger of the remaining count and the new count.
- R10: A CPU cycle with `cpu_we` 0 never starts a halt, whatever its address.
- R11: Leaving selective mode discards any pending count, so a return to selective mode does not resume an old halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address {bank, index} |
| cfg_wdata | input | 16 | Configuration write data |
| cpu_addr | input | 16 | CPU bus address |
| cpu_we | input | 1 | CPU write strobe |
| line_start | input | 1 | One-cycle pulse at the start of every scanline |
| line_vis | input | 1 | The current scanline is active display; valid with `line_start` |
| halt | output | 1 | Pause request to the CPU |

## Verification
Most internal faults surface at `halt` on the very next scanline boundary. A wrong pending count shows as a halt run that is too long or too short, counted in active lines after the triggering write. A wrong window decode shows as a halt on the wrong addresses, or a missing one. A count that is not cleared on a mode change appears as a stray halt on the first active line after selective mode is re-entered. A halt that moves mid-line shows between boundaries, within a few cycles of a write or a mode change.

// File: rtl/iowr_halt_pkg.sv
package iowr_halt_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_COMPAT = 2'd1,
        MODE_SEL    = 2'd2
    } halt_mode_e;

    typedef enum logic [1:0] {
        BANK_BASE  = 2'd0,
        BANK_MASK  = 2'd1,
        BANK_LINES = 2'd2,
        BANK_CTRL  = 2'd3
    } cfg_bank_e;

    // Unused code 3 falls back to off.
    function automatic halt_mode_e to_mode(input logic [1:0] code);
        case (code)
            2'd1:    return MODE_COMPAT;
            2'd2:    return MODE_SEL;
            default: return MODE_OFF;
        endcase
    endfunction

endpackage

// File: rtl/iowr_halt_regs.sv
module iowr_halt_regs
    import iowr_halt_pkg::*;
#(
    parameter int AW   = 16,
    parameter int CW   = 4,
    parameter int NREG = 4,
    parameter int IW   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [IW+1:0]   cfg_addr,
    input  logic [AW-1:0]   cfg_wdata,
    output logic [AW-1:0]   win_base  [NREG],
    output logic [AW-1:0]   win_mask  [NREG],
    output logic [CW-1:0]   win_lines [NREG],
    output halt_mode_e      mode
);

    cfg_bank_e       bank;
    logic [IW-1:0]   idx;

    assign bank = cfg_bank_e'(cfg_addr[IW+1:IW]);
    assign idx  = cfg_addr[IW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                win_base[i]  <= '0;
                win_mask[i]  <= '0;
                win_lines[i] <= '0;
            end
        end else if (cfg_we) begin
            for (int i = 0; i < NREG; i++) begin
                if (idx == IW'(i)) begin
                    case (bank)
                        BANK_BASE:  win_base[i]  <= cfg_wdata;
                        BANK_MASK:  win_mask[i]  <= cfg_wdata;
                        BANK_LINES: win_lines[i] <= cfg_wdata[CW-1:0];
                        default:    ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_OFF;
        end else if (cfg_we && bank == BANK_CTRL) begin
            mode <= to_mode(cfg_wdata[1:0]);
        end
    end

endmodule

// File: rtl/iowr_halt_match.sv
module iowr_halt_match #(
    parameter int AW   = 16,
    parameter int CW   = 4,
    parameter int NREG = 4
) (
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_we,
    input  logic [AW-1:0] win_base  [NREG],
    input  logic [AW-1:0] win_mask  [NREG],
    input  logic [CW-1:0] win_lines [NREG],
    output logic          hit,
    output logic [CW-1:0] req_lines
);

    logic [NREG-1:0] hit_vec;

    for (genvar g = 0; g < NREG; g++) begin : g_win
        assign hit_vec[g] = cpu_we && ((cpu_addr & win_mask[g]) == win_base[g]);
    end

    // Overlapping windows: the longest request wins.
    always_comb begin
        req_lines = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit_vec[i] && win_lines[i] > req_lines) begin
                req_lines = win_lines[i];
            end
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/iowr_halt_seq.sv
module iowr_halt_seq
    import iowr_halt_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  halt_mode_e    mode,
    input  logic          line_start,
    input  logic          line_vis,
    input  logic          hit,
    input  logic [CW-1:0] req_lines,
    output logic [CW-1:0] cnt,
    output logic          halt
);

    logic [CW-1:0] cnt_dec;
    logic [CW-1:0] cnt_nxt;
    logic          consume;

    assign consume = line_start && line_vis && (cnt != '0);

    always_comb begin
        cnt_dec = consume ? cnt - CW'(1) : cnt;
        if (mode != MODE_SEL) begin
            cnt_nxt = '0;
        end else if (hit && req_lines > cnt_dec) begin
            cnt_nxt = req_lines;
        end else begin
            cnt_nxt = cnt_dec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            halt <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            if (line_start) begin
                case (mode)
                    MODE_COMPAT: halt <= line_vis;
                    MODE_SEL:    halt <= line_vis && (cnt != '0);
                    default:     halt <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/iowr_halt_ctrl.sv
module iowr_halt_ctrl
    import iowr_halt_pkg::*;
#(
    parameter int AW   = 16,
    parameter int CW   = 4,
    parameter int NREG = 4,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [IW+1:0] cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_we,
    input  logic          line_start,
    input  logic          line_vis,
    output logic          halt
);

    logic [AW-1:0] win_base  [NREG];
    logic [AW-1:0] win_mask  [NREG];
    logic [CW-1:0] win_lines [NREG];
    halt_mode_e    mode_q;
    logic          snoop_hit;
    logic [CW-1:0] snoop_req;
    logic [CW-1:0] cnt_q;

    iowr_halt_regs #(.AW(AW), .CW(CW), .NREG(NREG), .IW(IW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .win_base  (win_base),
        .win_mask  (win_mask),
        .win_lines (win_lines),
        .mode      (mode_q)
    );

    iowr_halt_match #(.AW(AW), .CW(CW), .NREG(NREG)) u_match (
        .cpu_addr  (cpu_addr),
        .cpu_we    (cpu_we),
        .win_base  (win_base),
        .win_mask  (win_mask),
        .win_lines (win_lines),
        .hit       (snoop_hit),
        .req_lines (snoop_req)
    );

    iowr_halt_seq #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_q),
        .line_start (line_start),
        .line_vis   (line_vis),
        .hit        (snoop_hit),
        .req_lines  (snoop_req),
        .cnt        (cnt_q),
        .halt       (halt)
    );

endmodule

// File: rtl/iowr_halt_chk.sv
module iowr_halt_chk
    import iowr_halt_pkg::*;
#(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          line_start,
    input logic          line_vis,
    input logic          halt,
    input halt_mode_e    mode,
    input logic          hit,
    input logic [CW-1:0] req,
    input logic [CW-1:0] cnt
);

    p_line_bound_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(line_start) |-> $stable(halt));

    p_off_low_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(line_start) && $past(mode) == MODE_OFF) |-> !halt);

    p_compat_follow_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(line_start) && $past(mode) == MODE_COMPAT) |-> (halt == $past(line_vis)));

    p_blank_release_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(line_start) && !$past(line_vis)) |-> !halt);

    p_reload_max_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SEL && hit) |=> (cnt >= $past(req)));

    p_discard_r11: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_SEL) |=> (cnt == '0));

endmodule

bind iowr_halt_ctrl iowr_halt_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .line_vis   (line_vis),
    .halt       (halt),
    .mode       (mode_q),
    .hit        (snoop_hit),
    .req        (snoop_req),
    .cnt        (cnt_q)
);

// File: tb/iowr_halt_ctrl_bench.sv
module iowr_halt_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic        line_start = 1'b0;
    logic        line_vis = 1'b0;
    logic        halt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    iowr_halt_ctrl u_iowr_halt_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .line_start(line_start), .line_vis(line_vis), .halt(halt)
    );

    // {cpu_addr, cpu_we, expected halted lines}
    localparam logic [23:0] VEC [8] = '{
        24'h0812_15,   // R8: windows 0 and 3 both hit, 5 wins
        24'h0A00_13,   // R6: window 0 only
        24'h0105_11,   // R6: window 1
        24'h00F3_12,   // R6: window 2
        24'h00E3_10,   // R5: just outside window 2
        24'h1000_10,   // R5: outside window 0
        24'h0A00_00,   // R10: read of a window address
        24'h01FF_11    // R5: top of window 1
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cpu_cycle(input logic [15:0] a, input logic we);
        @(negedge clk);
        cpu_addr = a; cpu_we = we;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic line(input logic vis);
        @(negedge clk);
        line_start = 1'b1; line_vis = vis;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        cfg(4'hC, {14'd0, m});
    endtask

    task automatic fresh_sel();
        set_mode(2'd0);
        set_mode(2'd2);
    endtask

    task automatic count_halts(input int n, output int c, output int bad, input int exp);
        c = 0; bad = 0;
        for (int k = 0; k < n; k++) begin
            line(1'b1);
            if (halt) c++;
            if (halt != (k < exp)) bad++;
        end
    endtask

    initial begin
        int c;
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(halt == 1'b0, "R1 reset halt", halt, 0);
        line(1'b1);
        check(halt == 1'b0, "R1 mode off after reset", halt, 0);

        // windows: base, mask, lines
        cfg(4'h0, 16'h0800); cfg(4'h4, 16'hF800); cfg(4'h8, 16'd3);
        cfg(4'h1, 16'h0100); cfg(4'h5, 16'hFF00); cfg(4'h9, 16'd1);
        cfg(4'h2, 16'h00F0); cfg(4'h6, 16'hFFF0); cfg(4'hA, 16'd2);
        cfg(4'h3, 16'h0800); cfg(4'h7, 16'hFF00); cfg(4'hB, 16'd5);

        // R3: writes ignored while off
        cpu_cycle(16'h0A00, 1'b1);
        line(1'b1);
        check(halt == 1'b0, "R3 off no halt", halt, 0);
        set_mode(2'd2);
        line(1'b1);
        check(halt == 1'b0, "R3 off write not kept", halt, 0);

        // table walk
        for (int v = 0; v < 8; v++) begin
            fresh_sel();
            cpu_cycle(VEC[v][23:8], VEC[v][4]);
            count_halts(7, c, bad, int'(VEC[v][3:0]));
            check(bad == 0 && c == int'(VEC[v][3:0]), $sformatf("R6 vector %0d", v), c, int'(VEC[v][3:0]));
        end

        // R4 compatibility
        set_mode(2'd1);
        line(1'b1);
        check(halt == 1'b1, "R4 compat active", halt, 1);
        line(1'b0);
        check(halt == 1'b0, "R4 compat blank", halt, 0);
        line(1'b1);
        check(halt == 1'b1, "R4 compat active again", halt, 1);
        // R2: mode change mid-line does not move halt
        set_mode(2'd0);
        repeat (3) @(negedge clk);
        check(halt == 1'b1, "R2 holds until boundary", halt, 1);
        line(1'b1);
        check(halt == 1'b0, "R3 off at boundary", halt, 0);
        // R3: code 3 acts as off
        set_mode(2'd3);
        line(1'b1);
        check(halt == 1'b0, "R3 code 3 is off", halt, 0);

        // R7: blank lines do not consume
        fresh_sel();
        cpu_cycle(16'h0A00, 1'b1);
        line(1'b1); check(halt == 1'b1, "R7 line a", halt, 1);
        line(1'b0); check(halt == 1'b0, "R7 blank", halt, 0);
        line(1'b1); check(halt == 1'b1, "R7 line b", halt, 1);
        line(1'b1); check(halt == 1'b1, "R7 line c", halt, 1);
        line(1'b1); check(halt == 1'b0, "R7 released", halt, 0);

        // R9: shorter request during halt keeps the longer remainder
        fresh_sel();
        cpu_cycle(16'h0812, 1'b1);
        line(1'b1);
        check(halt == 1'b1, "R9 halt started", halt, 1);
        cpu_cycle(16'h0105, 1'b1);
        count_halts(6, c, bad, 4);
        check(bad == 0 && c == 4, "R9 max kept", c, 4);
        fresh_sel();
        cpu_cycle(16'h0105, 1'b1);
        cpu_cycle(16'h0A00, 1'b1);
        count_halts(5, c, bad, 3);
        check(bad == 0 && c == 3, "R9 longer replaces", c, 3);

        // R2: selective halt waits for boundary
        fresh_sel();
        cpu_cycle(16'h0A00, 1'b1);
        repeat (3) @(negedge clk);
        check(halt == 1'b0, "R2 no mid-line halt", halt, 0);
        line(1'b1);
        check(halt == 1'b1, "R2 halt at boundary", halt, 1);

        // R11: leaving selective discards the count
        fresh_sel();
        cpu_cycle(16'h0812, 1'b1);
        line(1'b1);
        set_mode(2'd0);
        set_mode(2'd2);
        line(1'b1);
        check(halt == 1'b0, "R11 pending discarded", halt, 0);

        // R6: zero-count window
        cfg(4'hA, 16'd0);
        fresh_sel();
        cpu_cycle(16'h00F3, 1'b1);
        count_halts(3, c, bad, 0);
        check(c == 0, "R6 zero count", c, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule